// File: doc/BRIEF.md
# Multi-Pin Edge-Count Response Compactor

This block compacts the response streams of several observed output pins of a unit under test into one edge count per pin. While a run is active, every sampled bit is compared with the bit sampled before it on the same pin. Each 0-to-1 or 1-to-0 change adds one to that pin's counter. A run of m samples per pin needs counters ceil(log2 m) bits wide; 16 million samples, for example, fit in 24 bits.

Before any run, a fault-free unit is measured once. Its per-pin counts are written into a small reference register file through a write port, and they stay there for every later run. When the end-of-run pulse arrives, each live count is compared with its reference. The block registers a per-pin mismatch vector and an overall pass flag, and it raises a done flag for one cycle.

A sequencer with four states runs the block. IDLE waits for start. PRIME waits for the first enabled sample, which only loads the previous-bit registers. COUNT accumulates edges. DONE lasts one cycle after the end pulse. The transitions are: start from any state goes to PRIME; an enabled sample in PRIME goes to COUNT; the end pulse in PRIME or COUNT goes to DONE; DONE always returns to IDLE.

Top module: `tcc_top`

## Requirements
- R1: In COUNT, each enabled sample whose bit differs from the previous enabled sample on that pin adds one to that pin's count. Samples taken while `smp_en_i` is low, and samples in the same cycle as `stop_i`, change nothing.
- R2: The first enabled sample after start only records the bit. For example, a run whose single sample is 1 ends with a count of 0.
- R3: A `start_i` pulse clears all counts, `mism_o` and `pass_o` at the following clock edge.
- R4: A count that reaches 2^CNT_W-1 stays there and does not wrap.
- R5: At `stop_i` during PRIME or COUNT, bit i of `mism_o` is set when count i differs from reference i. `pass_o` is 1 only when no bit of `mism_o` is set.
- R6: `done_o` is high for exactly one cycle, in the cycle after an accepted `stop_i`. A `stop_i` while IDLE produces no done and leaves the results unchanged.
- R7: `ref_we_i` writes `ref_data_i` into the reference for pin `ref_addr_i`. References keep their values across runs and are reset to 0.
- R8: A faulty stream with the same edge count as its reference passes. For example, 11101100 passes against a reference of 3, as does 11001100. The stream 10101010 gives 7.
- R9: Counts, `mism_o` and `pass_o` hold their values after done until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| resp_i | input | NPINS | Response bit of each observed pin |
| smp_en_i | input | 1 | Sample enable for resp_i |
| start_i | input | 1 | Start-of-run pulse |
| stop_i | input | 1 | End-of-run pulse |
| ref_we_i | input | 1 | Reference write enable |
| ref_addr_i | input | IDX_W | Pin index of the reference write |
| ref_data_i | input | CNT_W | Reference count value |
| cnt_o | output | NPINS*CNT_W | Live edge counts, pin i at bits [i*CNT_W +: CNT_W] |
| mism_o | output | NPINS | Registered per-pin mismatch flags |
| pass_o | output | 1 | Registered go/no-go result |
| done_o | output | 1 | One-cycle end-of-run flag |

## Verification
The assertions assume that `start_i` and `stop_i` come as single-cycle pulses and never in the same cycle. They also assume that references are not rewritten in the cycle of an end pulse, because the compare would then use a half-updated reference file. The bench holds every control input high for exactly one cycle and drives it on the falling clock edge. It writes references only while the block is idle. The stimulus also covers gaps in the sample enable and a stop issued while idle.

// File: rtl/tcc_pkg.sv
`timescale 1ns/1ps
package tcc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PRIME = 2'd1,
        ST_COUNT = 2'd2,
        ST_DONE  = 2'd3
    } tcc_state_e;
endpackage

// File: rtl/tcc_ctrl.sv
`timescale 1ns/1ps
module tcc_ctrl
    import tcc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic stop_i,
    input  logic smp_en_i,
    output logic clr_o,
    output logic load_o,
    output logic count_o,
    output logic capture_o,
    output logic done_o
);
    tcc_state_e state_q, state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (start_i) begin
            state_d = ST_PRIME;
        end else begin
            unique case (state_q)
                ST_IDLE:  state_d = ST_IDLE;
                ST_PRIME: begin
                    if (stop_i)        state_d = ST_DONE;
                    else if (smp_en_i) state_d = ST_COUNT;
                end
                ST_COUNT: begin
                    if (stop_i) state_d = ST_DONE;
                end
                ST_DONE:  state_d = ST_IDLE;
                default:  state_d = ST_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        clr_o     = start_i;
        load_o    = 1'b0;
        count_o   = 1'b0;
        capture_o = 1'b0;
        done_o    = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_PRIME: begin
                load_o    = smp_en_i && !stop_i && !start_i;
                capture_o = stop_i && !start_i;
            end
            ST_COUNT: begin
                count_o   = smp_en_i && !stop_i && !start_i;
                capture_o = stop_i && !start_i;
            end
            ST_DONE: done_o = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/tcc_lane.sv
`timescale 1ns/1ps
module tcc_lane #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             load_i,
    input  logic             count_i,
    input  logic             bit_i,
    output logic [CNT_W-1:0] cnt_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic             prev_q;
    logic [CNT_W-1:0] cnt_q;
    logic             edge_w;

    assign edge_w = count_i && (bit_i != prev_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
            cnt_q  <= '0;
        end else if (clr_i) begin
            prev_q <= 1'b0;
            cnt_q  <= '0;
        end else begin
            if (load_i || count_i) prev_q <= bit_i;
            if (edge_w && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
        end
    end

    assign cnt_o = cnt_q;
endmodule

// File: rtl/tcc_refs.sv
`timescale 1ns/1ps
module tcc_refs #(
    parameter int NPINS = 4,
    parameter int CNT_W = 8,
    parameter int IDX_W = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   we_i,
    input  logic [IDX_W-1:0]       addr_i,
    input  logic [CNT_W-1:0]       data_i,
    output logic [NPINS*CNT_W-1:0] refs_o
);
    for (genvar g = 0; g < NPINS; g++) begin : g_slot
        logic [CNT_W-1:0] slot_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) slot_q <= '0;
            else if (we_i && addr_i == IDX_W'(g)) slot_q <= data_i;
        end
        assign refs_o[g*CNT_W +: CNT_W] = slot_q;
    end
endmodule

// File: rtl/tcc_top.sv
`timescale 1ns/1ps
module tcc_top #(
    parameter int NPINS = 4,
    parameter int CNT_W = 8,
    localparam int IDX_W = (NPINS > 1) ? $clog2(NPINS) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NPINS-1:0]       resp_i,
    input  logic                   smp_en_i,
    input  logic                   start_i,
    input  logic                   stop_i,
    input  logic                   ref_we_i,
    input  logic [IDX_W-1:0]       ref_addr_i,
    input  logic [CNT_W-1:0]       ref_data_i,
    output logic [NPINS*CNT_W-1:0] cnt_o,
    output logic [NPINS-1:0]       mism_o,
    output logic                   pass_o,
    output logic                   done_o
);
    logic clr_w, load_w, count_w, capture_w;
    logic [NPINS*CNT_W-1:0] refs_w;
    logic [NPINS-1:0]       neq_w;
    logic [NPINS-1:0]       mism_q;
    logic                   pass_q;

    tcc_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .stop_i    (stop_i),
        .smp_en_i  (smp_en_i),
        .clr_o     (clr_w),
        .load_o    (load_w),
        .count_o   (count_w),
        .capture_o (capture_w),
        .done_o    (done_o)
    );

    tcc_refs #(.NPINS(NPINS), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_refs (
        .clk    (clk),
        .rst_n  (rst_n),
        .we_i   (ref_we_i),
        .addr_i (ref_addr_i),
        .data_i (ref_data_i),
        .refs_o (refs_w)
    );

    for (genvar g = 0; g < NPINS; g++) begin : g_lane
        tcc_lane #(.CNT_W(CNT_W)) u_lane (
            .clk     (clk),
            .rst_n   (rst_n),
            .clr_i   (clr_w),
            .load_i  (load_w),
            .count_i (count_w),
            .bit_i   (resp_i[g]),
            .cnt_o   (cnt_o[g*CNT_W +: CNT_W])
        );
        assign neq_w[g] = cnt_o[g*CNT_W +: CNT_W] != refs_w[g*CNT_W +: CNT_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mism_q <= '0;
            pass_q <= 1'b0;
        end else if (clr_w) begin
            mism_q <= '0;
            pass_q <= 1'b0;
        end else if (capture_w) begin
            mism_q <= neq_w;
            pass_q <= ~|neq_w;
        end
    end

    assign mism_o = mism_q;
    assign pass_o = pass_q;
endmodule

// File: rtl/tcc_chk.sv
`timescale 1ns/1ps
module tcc_chk #(
    parameter int NPINS = 4,
    parameter int CNT_W = 8
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   start_i,
    input logic                   stop_i,
    input logic [NPINS*CNT_W-1:0] cnt_o,
    input logic [NPINS-1:0]       mism_o,
    input logic                   pass_o,
    input logic                   done_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R6

    AST_DONE_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(stop_i)); // R6

    AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (cnt_o == '0 && mism_o == '0 && !pass_o)); // R3

    AST_PASS_AGREES: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (pass_o == (mism_o == '0))); // R5

    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_i && !stop_i) |=> ($stable(mism_o) && $stable(pass_o))); // R9

    for (genvar g = 0; g < NPINS; g++) begin : g_pin
        AST_NO_DECREASE: assert property (@(posedge clk) disable iff (!rst_n)
            !start_i |=> cnt_o[g*CNT_W +: CNT_W] >= $past(cnt_o[g*CNT_W +: CNT_W])); // R1
        AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
            (cnt_o[g*CNT_W +: CNT_W] == CNT_MAX && !start_i) |=> cnt_o[g*CNT_W +: CNT_W] == CNT_MAX); // R4
        AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
            !start_i |=> (cnt_o[g*CNT_W +: CNT_W] - $past(cnt_o[g*CNT_W +: CNT_W])) <= 1); // R1
    end
endmodule

bind tcc_top tcc_chk #(.NPINS(NPINS), .CNT_W(CNT_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .stop_i  (stop_i),
    .cnt_o   (cnt_o),
    .mism_o  (mism_o),
    .pass_o  (pass_o),
    .done_o  (done_o)
);

// File: tb/sim_tcc_top.sv
`timescale 1ns/1ps
module sim_tcc_top;
    localparam int NPINS = 4;
    localparam int CNT_W = 8;
    localparam int IDX_W = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NPINS-1:0] resp_i = '0;
    logic smp_en_i = 1'b0, start_i = 1'b0, stop_i = 1'b0, ref_we_i = 1'b0;
    logic [IDX_W-1:0] ref_addr_i = '0;
    logic [CNT_W-1:0] ref_data_i = '0;
    logic [NPINS*CNT_W-1:0] cnt_o;
    logic [NPINS-1:0] mism_o;
    logic pass_o, done_o;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    tcc_top #(.NPINS(NPINS), .CNT_W(CNT_W)) u0 (
        .clk(clk), .rst_n(rst_n), .resp_i(resp_i), .smp_en_i(smp_en_i),
        .start_i(start_i), .stop_i(stop_i), .ref_we_i(ref_we_i),
        .ref_addr_i(ref_addr_i), .ref_data_i(ref_data_i),
        .cnt_o(cnt_o), .mism_o(mism_o), .pass_o(pass_o), .done_o(done_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] cnt_of(input int p);
        return 32'(cnt_o[p*CNT_W +: CNT_W]);
    endfunction

    task automatic tick();
        @(negedge clk);
        start_i = 0; stop_i = 0; smp_en_i = 0; ref_we_i = 0;
    endtask

    task automatic wr_ref(input int p, input int v);
        ref_we_i = 1; ref_addr_i = IDX_W'(p); ref_data_i = CNT_W'(v);
        tick();
    endtask

    task automatic do_start();
        start_i = 1; tick();
    endtask

    task automatic sample(input logic [NPINS-1:0] b);
        resp_i = b; smp_en_i = 1; tick();
    endtask

    task automatic do_stop();
        stop_i = 1; tick();
    endtask

    task automatic run8(input logic [7:0] p0, p1, p2, p3);
        do_start();
        for (int i = 7; i >= 0; i--) sample({p3[i], p2[i], p1[i], p0[i]});
        do_stop();
    endtask

    task automatic t_reset();
        chk("R3 reset counts", cnt_o, 0);
        chk("R3 reset mism", 32'(mism_o), 0);
        chk("R3 reset pass", 32'(pass_o), 0);
        chk("R6 reset done", 32'(done_o), 0);
    endtask

    task automatic t_golden();
        wr_ref(0, 7); wr_ref(1, 3); wr_ref(2, 3); wr_ref(3, 0);
        run8(8'b10101010, 8'b11001100, 8'b11101100, 8'b00000000);
        chk("R6 done after stop", 32'(done_o), 1);
        chk("R8 count 10101010", cnt_of(0), 7);
        chk("R8 count 11001100", cnt_of(1), 3);
        chk("R8 masked count 11101100", cnt_of(2), 3);
        chk("R1 constant pin", cnt_of(3), 0);
        chk("R8 masked stream passes", 32'(pass_o), 1);
        chk("R5 no mismatch", 32'(mism_o), 0);
        tick();
        chk("R6 done one cycle", 32'(done_o), 0);
        repeat (3) tick();
        chk("R9 pass held", 32'(pass_o), 1);
        chk("R9 count held", cnt_of(0), 7);
    endtask

    task automatic t_mismatch();
        wr_ref(3, 1);
        run8(8'b10101010, 8'b11001100, 8'b11101100, 8'b00000000);
        chk("R5 mism vector", 32'(mism_o), 32'b1000);
        chk("R5 fail", 32'(pass_o), 0);
        chk("R7 ref persists pin0", 32'(mism_o[0]), 0);
        tick();
        stop_i = 1; tick();
        chk("R6 stop in idle no done", 32'(done_o), 0);
        chk("R6 stop in idle keeps mism", 32'(mism_o), 32'b1000);
        do_start();
        chk("R3 start clears mism", 32'(mism_o), 0);
        chk("R3 start clears counts", cnt_o, 0);
        do_stop();
        wr_ref(3, 0);
    endtask

    task automatic t_first_and_gaps();
        do_start();
        sample(4'b1111);
        chk("R2 first sample no count", cnt_of(0), 0);
        for (int i = 0; i < 5; i++) begin
            resp_i = 4'(i); smp_en_i = 0; tick();
        end
        chk("R1 disabled samples ignored", cnt_of(1), 0);
        sample(4'b1111);
        chk("R1 same bit no count", cnt_of(0), 0);
        sample(4'b0101);
        chk("R1 edge counted", cnt_of(1), 1);
        chk("R1 no edge pin0", cnt_of(0), 0);
        resp_i = 4'b1111; smp_en_i = 1; stop_i = 1; tick();
        chk("R1 sample with stop ignored", cnt_of(1), 1);
        chk("R6 done", 32'(done_o), 1);
        tick();
    endtask

    task automatic t_saturate();
        wr_ref(0, 255); wr_ref(1, 0); wr_ref(2, 0); wr_ref(3, 0);
        do_start();
        for (int i = 0; i < 300; i++) sample({3'b000, 1'(i)});
        chk("R4 saturated", cnt_of(0), 255);
        do_stop();
        chk("R4 saturated passes", 32'(pass_o), 1);
        chk("R7 ref 255 match", 32'(mism_o), 0);
        tick();
    endtask

    initial begin
        #(200000 * 5);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1;
        tick();
        t_golden();
        t_mismatch();
        t_first_and_gaps();
        t_saturate();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule